// File: doc/BRIEF.md
# Display FIFO refill timing calculator

This block works out when a display engine should start and stop refilling its pixel FIFO from memory. It takes the memory and pixel clock divider settings, the pixel depth, the FIFO depth, two memory access delays and a loop latency. From these it derives a fixed-point precision that suits the size of the numbers, a turn-off threshold and a turn-on threshold, and a count of memory clocks per FIFO entry. The thresholds are rounded to the chosen precision grain, and the on-threshold is pulled below the off-threshold when the two would otherwise collide.

A single restoring divider is shared by every quotient in the calculation, so one computation takes about 170 clock cycles. The caller pulses `start_i` with stable inputs. When `done_o` pulses, two packed register words are ready: one holds the on/off thresholds and one holds precision, latency and the clock count. Both words then hold their values until the next result. All arithmetic is unsigned and wraps modulo 2^32.

Top module: `fifo_refill_calc`

## Requirements
- R1: While reset is high and on the first cycle after it, `done_o` is 0 and `on_off_o` and `config_o` are 0.
- R2: Operand preparation. The multiplier M is mem_fb × pix_post. The divisor D is pix_fb × mem_post, and it is further multiplied by floor(bpp/4) when bpp ≥ 8. Both are then halved together while both are even. The base shift B is 3 when bpp = 0 and 4 otherwise.
- R3: Precision P is the bit length of ((M × depth) << B) / D, minus 5, clamped to the range 0..7. P appears in `config_o` bits 22:20. The scale S(x) is x << (6 − P), and S(x) is x >> 1 when P = 7. The working shift V is B + 6 − P.
- R4: The off threshold is ((M × (depth − 1)) << V) / D − (1 << B).
- R5: The unrounded on threshold starts at ((M << V) + D) / D. It is raised to at least T = S(ras_dly) + 1, and then 2T + S(page_dly) is added to it.
- R6: The on threshold is rounded up to a multiple of the grain G = 2^(6 − P), or G = 1 when P = 7.
- R7: If the rounded on threshold is at least the off threshold rounded down to a multiple of G, the on threshold becomes off − ((M << V) / D), rounded down to a multiple of G.
- R8: `config_o` equals (P << 20) | (latency << 16) | X, where X = ((M << (V + 5)) + D) / D.
- R9: `on_off_o` equals on × 65536 + off, modulo 2^32.
- R10: Each accepted `start_i` yields exactly one `done_o` pulse, which lasts one cycle. A `start_i` that arrives while a computation is in progress is ignored and does not change the result.
- R11: `on_off_o` and `config_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a computation (accepted only when idle) |
| mem_fb_i | input | FB_W | Memory clock feedback divider |
| pix_post_i | input | POST_W | Pixel clock post-divide factor |
| pix_fb_i | input | FB_W | Pixel clock feedback divider |
| mem_post_i | input | POST_W | Memory clock post-divide factor |
| bpp_i | input | BPP_W | Bits per pixel (0 selects the narrow-FIFO mode) |
| depth_i | input | DEPTH_W | FIFO depth in entries |
| page_dly_i | input | DLY_W | Page-miss delay in memory clocks |
| ras_dly_i | input | DLY_W | Row-active delay in memory clocks |
| latency_i | input | LAT_W | Loop latency copied into the config word |
| on_off_o | output | 32 | Packed on/off thresholds |
| config_o | output | 32 | Packed precision, latency and clock count |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that the divisor is never zero. This holds when both feedback dividers and both post factors are nonzero and the FIFO depth is at least one. They also assume that `start_i` arrives only with inputs held stable for that cycle. The stimulus draws feedback dividers from the 8-bit range, post factors from {1, 2, 3, 4, 8}, pixel depths from {0, 4, 8, 16, 24, 32} and depths up to 63, so the products and shifts fit in 32 bits. Only the threshold subtraction is allowed to wrap, and one case sets this up on purpose. Precision cases at both clamps, a collision case and an overlapping start are all included.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int DW       = 32;
  localparam int PREC_W   = 3;
  localparam int PREC_MAX = 7;
  localparam int PREC_POS = 20;
  localparam int LAT_POS  = 16;
  localparam int ON_POS   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREC, ST_OFF, ST_ON, ST_CLAMP, ST_XCLK
  } phase_t;

  // scale by 2^(6-p); the top precision scales by one half
  function automatic logic [DW-1:0] frac_scale(input logic [DW-1:0] v,
                                               input logic [PREC_W-1:0] p);
    if (p == PREC_W'(PREC_MAX)) frac_scale = v >> 1;
    else                        frac_scale = v << (3'd6 - p);
  endfunction

  // log2 of the rounding grain
  function automatic logic [PREC_W-1:0] grain_exp(input logic [PREC_W-1:0] p);
    grain_exp = (p == PREC_W'(PREC_MAX)) ? '0 : 3'd6 - p;
  endfunction
endpackage

// File: rtl/refill_norm.sv
module refill_norm
  import refill_pkg::*;
#(
  parameter int FB_W   = 8,
  parameter int POST_W = 4,
  parameter int BPP_W  = 8
) (
  input  logic [FB_W-1:0]   mfb_i,
  input  logic [POST_W-1:0] ppost_i,
  input  logic [FB_W-1:0]   pfb_i,
  input  logic [POST_W-1:0] mpost_i,
  input  logic [BPP_W-1:0]  bpp_i,
  output logic [DW-1:0]     mul_o,
  output logic [DW-1:0]     den_o,
  output logic [3:0]        base_sh_o
);
  localparam int TZ_W = $clog2(DW) + 1;

  logic [DW-1:0]   m0, d0, d1, both;
  logic [TZ_W-1:0] tz;

  always_comb begin
    m0 = DW'(mfb_i) * DW'(ppost_i);
    d0 = DW'(pfb_i) * DW'(mpost_i);
    d1 = (bpp_i >= BPP_W'(8)) ? d0 * DW'(bpp_i >> 2) : d0;
    both = m0 | d1;
    tz = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (both[i]) tz = TZ_W'(i);
    end
    mul_o     = m0 >> tz;
    den_o     = d1 >> tz;
    base_sh_o = (bpp_i == '0) ? 4'd3 : 4'd4;
  end
endmodule

// File: rtl/refill_prec.sv
module refill_prec
  import refill_pkg::*;
(
  input  logic [DW-1:0]     q_i,
  output logic [PREC_W-1:0] prec_o
);
  localparam int BL_W = $clog2(DW) + 1;

  logic [BL_W-1:0] blen;

  always_comb begin
    blen = '0;
    for (int i = 0; i < DW; i++) begin
      if (q_i[i]) blen = BL_W'(i + 1);
    end
    if (blen <= BL_W'(5))
      prec_o = '0;
    else if (blen >= BL_W'(5 + PREC_MAX))
      prec_o = PREC_W'(PREC_MAX);
    else
      prec_o = PREC_W'(blen - BL_W'(5));
  end
endmodule

// File: rtl/refill_divider.sv
module refill_divider
  import refill_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quo_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_r, qr, den_r, num_r;
  logic [CW-1:0] cnt;
  logic [DW:0]   shifted, diff;

  always_comb begin
    shifted = {rem_r, qr[DW-1]};
    diff    = shifted - {1'b0, den_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r  <= '0;
      qr     <= '0;
      den_r  <= '0;
      num_r  <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !busy_o) begin
        rem_r  <= '0;
        qr     <= num_i;
        num_r  <= num_i;
        den_r  <= den_i;
        cnt    <= CW'(DW);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (!diff[DW]) begin
          rem_r <= diff[DW-1:0];
          qr    <= {qr[DW-2:0], 1'b1};
        end else begin
          rem_r <= shifted[DW-1:0];
          qr    <= {qr[DW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = qr;

  // R2: prepared divisor must never be zero
  assert_nonzero_den_R2: assert property (@(posedge clk) disable iff (rst)
    (go_i && !busy_o) |-> (den_i != '0));

  // R4: every quotient is the exact floor of the stored operands
  assert_quotient_exact_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (({{DW{1'b0}}, quo_o} * {{DW{1'b0}}, den_r}) <= {{DW{1'b0}}, num_r}) &&
               (({{DW{1'b0}}, num_r} - ({{DW{1'b0}}, quo_o} * {{DW{1'b0}}, den_r}))
                  < {{DW{1'b0}}, den_r}));
endmodule

// File: rtl/fifo_refill_calc.sv
module fifo_refill_calc
  import refill_pkg::*;
#(
  parameter int FB_W    = 8,
  parameter int POST_W  = 4,
  parameter int BPP_W   = 8,
  parameter int DEPTH_W = 6,
  parameter int DLY_W   = 5,
  parameter int LAT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [FB_W-1:0]    mem_fb_i,
  input  logic [POST_W-1:0]  pix_post_i,
  input  logic [FB_W-1:0]    pix_fb_i,
  input  logic [POST_W-1:0]  mem_post_i,
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [DLY_W-1:0]   page_dly_i,
  input  logic [DLY_W-1:0]   ras_dly_i,
  input  logic [LAT_W-1:0]   latency_i,
  output logic [DW-1:0]      on_off_o,
  output logic [DW-1:0]      config_o,
  output logic               done_o
);
  phase_t st;
  logic   issued;

  logic [DW-1:0]     mul_r, den_r, depth_r, pf_r, ras_r, off_r, on_r;
  logic [3:0]        bsh_r;
  logic [LAT_W-1:0]  lat_r;
  logic [PREC_W-1:0] prec_r;

  logic [DW-1:0]     n_mul, n_den;
  logic [3:0]        n_bsh;
  logic [PREC_W-1:0] p_new;

  logic          dv_go, dv_busy, dv_done;
  logic [DW-1:0] dv_num, dv_quo;

  logic [4:0]    vsh2;
  logic [DW-1:0] gmask, t_val, on_base, on_raw, on_rnd, off_flr;

  refill_norm #(.FB_W(FB_W), .POST_W(POST_W), .BPP_W(BPP_W)) u_norm (
    .mfb_i(mem_fb_i), .ppost_i(pix_post_i), .pfb_i(pix_fb_i),
    .mpost_i(mem_post_i), .bpp_i(bpp_i),
    .mul_o(n_mul), .den_o(n_den), .base_sh_o(n_bsh)
  );

  refill_prec u_prec (.q_i(dv_quo), .prec_o(p_new));

  refill_divider u_div (
    .clk(clk), .rst(rst), .go_i(dv_go), .num_i(dv_num), .den_i(den_r),
    .busy_o(dv_busy), .done_o(dv_done), .quo_o(dv_quo)
  );

  // threshold arithmetic for the current precision
  always_comb begin
    vsh2    = 5'(bsh_r) + 5'd6 - 5'(prec_r);
    gmask   = (DW'(1) << grain_exp(prec_r)) - DW'(1);
    t_val   = frac_scale(ras_r, prec_r) + DW'(1);
    on_base = (dv_quo > t_val) ? dv_quo : t_val;
    on_raw  = on_base + (t_val << 1) + frac_scale(pf_r, prec_r);
    on_rnd  = (on_raw + gmask) & ~gmask;
    off_flr = off_r & ~gmask;
  end

  // dividend for the phase in progress
  always_comb begin
    case (st)
      ST_PREC:  dv_num = (mul_r * depth_r) << bsh_r;
      ST_OFF:   dv_num = (mul_r * (depth_r - DW'(1))) << vsh2;
      ST_ON:    dv_num = (mul_r << vsh2) + den_r;
      ST_CLAMP: dv_num = mul_r << vsh2;
      ST_XCLK:  dv_num = (mul_r << (vsh2 + 5'd5)) + den_r;
      default:  dv_num = '0;
    endcase
  end

  assign dv_go = (st != ST_IDLE) && !issued && !dv_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      issued   <= 1'b0;
      mul_r    <= '0;
      den_r    <= '0;
      bsh_r    <= '0;
      depth_r  <= '0;
      pf_r     <= '0;
      ras_r    <= '0;
      lat_r    <= '0;
      prec_r   <= '0;
      off_r    <= '0;
      on_r     <= '0;
      on_off_o <= '0;
      config_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (dv_go) issued <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            mul_r   <= n_mul;
            den_r   <= n_den;
            bsh_r   <= n_bsh;
            depth_r <= DW'(depth_i);
            pf_r    <= DW'(page_dly_i);
            ras_r   <= DW'(ras_dly_i);
            lat_r   <= latency_i;
            st      <= ST_PREC;
          end
        end
        ST_PREC: begin
          if (dv_done) begin
            prec_r <= p_new;
            issued <= 1'b0;
            st     <= ST_OFF;
          end
        end
        ST_OFF: begin
          if (dv_done) begin
            off_r  <= dv_quo - (DW'(1) << bsh_r);
            issued <= 1'b0;
            st     <= ST_ON;
          end
        end
        ST_ON: begin
          if (dv_done) begin
            issued <= 1'b0;
            if (on_rnd >= off_flr) begin
              st <= ST_CLAMP;
            end else begin
              on_r <= on_rnd;
              st   <= ST_XCLK;
            end
          end
        end
        ST_CLAMP: begin
          if (dv_done) begin
            on_r   <= (off_r - dv_quo) & ~gmask;
            issued <= 1'b0;
            st     <= ST_XCLK;
          end
        end
        ST_XCLK: begin
          if (dv_done) begin
            on_off_o <= (on_r << ON_POS) + off_r;
            config_o <= (DW'(prec_r) << PREC_POS) | (DW'(lat_r) << LAT_POS) | dv_quo;
            done_o   <= 1'b1;
            issued   <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: single-cycle strobe
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: a start during a computation leaves the prepared operands alone
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && start_i) |=> ($stable(mul_r) && $stable(den_r) && $stable(lat_r)));

  // R11: result words move only with the strobe
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(on_off_o) && $stable(config_o)));

  // R6: the on threshold sits on the precision grain before packing
  assert_on_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XCLK) |-> ((on_r & gmask) == '0));
endmodule

// File: tb/sim_fifo_refill_calc.sv
module sim_fifo_refill_calc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  mfb = '0, pfb = '0, bpp = '0;
  logic [3:0]  ppost = '0, mpost = '0, lat = '0;
  logic [5:0]  depth = '0;
  logic [4:0]  pgd = '0, rasd = '0;
  logic [31:0] on_off, cfg;
  logic        done;

  fifo_refill_calc u0 (
    .clk(clk), .rst(rst), .start_i(start),
    .mem_fb_i(mfb), .pix_post_i(ppost), .pix_fb_i(pfb), .mem_post_i(mpost),
    .bpp_i(bpp), .depth_i(depth), .page_dly_i(pgd), .ras_dly_i(rasd),
    .latency_i(lat), .on_off_o(on_off), .config_o(cfg), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit [31:0] oo; bit [31:0] cf; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit [31:0] last_oo = '0, last_cf = '0;
  bit was_done = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string what, input bit [31:0] act, input bit [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  // reference computation written from the requirements
  task automatic model(input int unsigned a_mfb, a_pp, a_pfb, a_mp, a_bpp, a_dep,
                       a_pg, a_ras, a_lat, output bit [31:0] eo, output bit [31:0] ec);
    bit [31:0] m, d, q, off, on, t, g, sv, xc, sc_ras, sc_pg;
    int bl, p, vb, v;
    m = 32'(a_mfb) * 32'(a_pp);                        // R2
    d = 32'(a_pfb) * 32'(a_mp);
    if (a_bpp >= 8) d = d * 32'(a_bpp / 4);
    vb = (a_bpp == 0) ? 3 : 4;
    while (m[0] == 1'b0 && d[0] == 1'b0) begin m = m >> 1; d = d >> 1; end
    q = ((m * 32'(a_dep)) << vb) / d;                  // R3
    bl = 0;
    while (q != 0) begin bl++; q = q >> 1; end
    p = (bl < 5) ? 0 : ((bl - 5 > 7) ? 7 : bl - 5);
    if (p == 7) begin
      v = vb - 1; g = 1; sc_ras = 32'(a_ras) >> 1; sc_pg = 32'(a_pg) >> 1;
    end else begin
      v = vb + 6 - p; g = 32'd1 << (6 - p);
      sc_ras = 32'(a_ras) << (6 - p); sc_pg = 32'(a_pg) << (6 - p);
    end
    off = ((m * (32'(a_dep) - 1)) << v) / d - (32'd1 << vb);   // R4
    on = ((m << v) + d) / d;                                    // R5
    t = sc_ras + 1;
    if (on < t) on = t;
    on = on + 2 * t + sc_pg;
    on = ((on + g - 1) / g) * g;                                // R6
    if (on >= (off / g) * g) begin                              // R7
      sv = (m << v) / d;
      on = ((off - sv) / g) * g;
    end
    xc = ((m << (v + 5)) + d) / d;                              // R8
    eo = (on << 16) + off;                                      // R9
    ec = (32'(p) << 20) | (32'(a_lat) << 16) | xc;
  endtask

  task automatic drive(input int unsigned a_mfb, a_pp, a_pfb, a_mp, a_bpp, a_dep,
                       a_pg, a_ras, a_lat);
    @(negedge clk);
    mfb = 8'(a_mfb); ppost = 4'(a_pp); pfb = 8'(a_pfb); mpost = 4'(a_mp);
    bpp = 8'(a_bpp); depth = 6'(a_dep); pgd = 5'(a_pg); rasd = 5'(a_ras);
    lat = 4'(a_lat); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_job(input int unsigned a_mfb, a_pp, a_pfb, a_mp, a_bpp, a_dep,
                         a_pg, a_ras, a_lat);
    exp_t e;
    model(a_mfb, a_pp, a_pfb, a_mp, a_bpp, a_dep, a_pg, a_ras, a_lat, e.oo, e.cf);
    exp_q.push_back(e);
    drive(a_mfb, a_pp, a_pfb, a_mp, a_bpp, a_dep, a_pg, a_ras, a_lat);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops the scoreboard when the strobe appears
  always @(negedge clk) begin
    if (!rst) begin
      if (was_done) check(!done, "R10 strobe longer than one cycle", 32'(done), 32'd0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 strobe with no accepted start", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(on_off == e.oo, "R4 R5 R6 R7 R9 on_off word", on_off, e.oo);
          check(cfg == e.cf, "R2 R3 R8 config word", cfg, e.cf);
          last_oo = e.oo;
          last_cf = e.cf;
        end
      end
      was_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done during reset", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
    check(on_off == 32'd0, "R1 on_off after reset", on_off, 32'd0);
    check(cfg == 32'd0, "R1 config after reset", cfg, 32'd0);

    // R2 R3: typical accelerator-mode settings
    run_job(200, 2, 180, 2, 8, 32, 7, 9, 8);   wait_idle();
    // R2: bpp 0 selects base shift 3
    run_job(200, 2, 180, 2, 0, 32, 7, 9, 10);  wait_idle();
    run_job(150, 4, 130, 1, 32, 24, 5, 6, 11); wait_idle();
    run_job(170, 1, 220, 2, 16, 24, 3, 4, 9);  wait_idle();
    // R3: precision clamped at 0
    run_job(16, 1, 255, 8, 32, 1, 2, 3, 1);    wait_idle();
    // R3: precision clamped at 7, half-scale path
    run_job(255, 8, 1, 1, 4, 63, 9, 13, 15);   wait_idle();
    // R7: on threshold collides with off threshold (wrapping subtraction)
    run_job(128, 1, 255, 8, 8, 2, 31, 31, 5);  wait_idle();
    // R6 R7: mid precisions with large delays
    run_job(240, 3, 129, 4, 24, 16, 20, 25, 7); wait_idle();
    run_job(131, 8, 140, 3, 8, 63, 0, 0, 0);   wait_idle();

    // R10: a second start while busy is ignored
    run_job(190, 2, 160, 4, 16, 32, 11, 12, 6);
    repeat (20) @(negedge clk);
    drive(10, 1, 250, 8, 32, 5, 1, 1, 3);
    wait_idle();
    repeat (300) @(negedge clk);
    // R11: outputs hold their last result while idle
    check(on_off == last_oo, "R11 on_off held while idle", on_off, last_oo);
    check(cfg == last_cf, "R11 config held while idle", cfg, last_cf);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule